// File: doc/BRIEF.md
# Two-Wire Bus Slave with Page-Write Engine

This block is a serial bus slave for a two-wire (SCL/SDA) interface. It watches the bus on a fast system clock, answers only to an address byte made of a fixed 1010 type nibble followed by three bits that match its strap pins, and gives access to an 80-byte space from 80h to CFh. The lower sixteen bytes (80h to 8Fh) form a register bank held in flip-flops. The upper 64 bytes (90h to CFh) are a table held in a RAM that infers as block memory. A register at 86h holds a write-enable latch in bit 7, and every store except to 86h is refused while that latch is clear.

Writes arrive as a device byte with R/W=0, a word-address byte, then one or more data bytes. The address advances inside its 16-byte page and wraps to the start of the page. Reads use a dummy write of the word address, a repeated start and a device byte with R/W=1; the pointer then advances through the whole space after every byte. A stop that closes a write which stored anything other than 86h starts a timed busy period. The slave ignores the bus for the whole period, so a master can poll for the acknowledge to learn when it has ended. Every stored byte also appears for one clock on an outgoing memory port.

Top module: `tws_slave`

## Requirements
- R1: A device byte is acknowledged only when its upper nibble is 1010 and bits 3..1 equal the strap pins (bit 3 = pin 2); otherwise SDA stays released for that byte and every following byte until the next start.
- R2: Bytes move most significant bit first, the receiver acknowledges by holding SDA low through the ninth clock, and the slave changes its SDA drive only while SCL is low.
- R3: A word address from 80h to CFh is acknowledged and loaded into the pointer; any other value is not acknowledged and the slave returns to idle.
- R4: During a write the pointer advances only in its low four bits and wraps within its 16-byte page: twelve bytes from 9Bh land at 9Bh..9Fh and then 90h..96h.
- R5: A write of more than sixteen bytes into one page overwrites the earliest bytes in order, so byte 17 replaces the first address written.
- R6: Bit 7 of 86h is the write-enable latch, cleared by reset; while it is 0 a data byte to any address other than 86h is neither acknowledged nor stored, and a write to 86h keeps only bit 7 (bits 6..0 read back as 0).
- R7: After a data byte is stored at 80h, 85h or 86h, further data bytes of the same transfer are not acknowledged and not stored.
- R8: A stop after a transfer that stored a byte at an address other than 86h starts a busy period of BUSY_CYCLES clocks during which no device byte of either R/W value is acknowledged; a write only to 86h starts none.
- R9: In a read the slave sends the byte at the pointer, advances the pointer after each byte, wraps from CFh to 80h, and keeps sending while the master acknowledges.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start or stop.
- R11: Each stored byte is shown on the memory port as a one-clock pulse of mem_we with its address and the data byte as received.
- R12: After reset SDA is released, mem_we is low, the register bank reads as zero and no busy period is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| dev_pins | input | 3 | Strapped device address bits |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| mem_we | output | 1 | One-clock pulse per stored byte |
| mem_addr | output | 8 | Address of the stored byte |
| mem_wdata | output | 8 | Data byte as received from the bus |

## Verification
The bench aims at the page wrap from offset 11 and at a seventeen-byte overrun, where a design that carried into the page bits would scatter bytes into the next page and reads would show the wrong layout. It probes the bus during the busy period with both R/W values, which a design that only blocked writes would answer. It drives extra data bytes after 80h and 86h and data with the write-enable latch clear, where a wrong design would acknowledge and emit stray pulses on the memory port. It also reads across the CFh-to-80h wrap, ends a read with a master no-acknowledge, and clocks a further byte to catch a slave that keeps driving the line.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_DECIDE,
    ST_ACK,
    ST_TX,
    ST_RACK
  } eng_state_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_PTR,
    RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_busy.sv
module tws_busy #(
  parameter int BUSY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (kick) begin
      remain <= CW'(BUSY_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy = (remain != '0);

  // R8: the timer never holds more than one full busy period
  a_r8_busy_bound: assert property (@(posedge clk) disable iff (rst)
    remain <= CW'(BUSY_CYCLES));

  // R8: a kick always opens a busy window on the next cycle
  a_r8_kick_busy: assert property (@(posedge clk) disable iff (rst)
    kick |=> busy);
endmodule

// File: rtl/tws_store.sv
module tws_store #(
  parameter logic [7:0] SPACE_LO   = 8'h80,
  parameter logic [7:0] SPACE_HI   = 8'hCF,
  parameter logic [7:0] TABLE_LO   = 8'h90,
  parameter logic [7:0] LATCH_ADDR = 8'h86,
  parameter logic [7:0] LATCH_KEEP = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata,
  output logic       wr_latch
);
  localparam int REG_N  = int'(TABLE_LO) - int'(SPACE_LO);
  localparam int TBL_N  = int'(SPACE_HI) - int'(TABLE_LO) + 1;
  localparam int REG_AW = $clog2(REG_N);
  localparam int TBL_AW = $clog2(TBL_N);
  localparam int LIDX   = int'(LATCH_ADDR) - int'(SPACE_LO);

  logic [7:0] regs [REG_N];
  logic [7:0] ram  [TBL_N];
  logic [7:0] reg_q;
  logic [7:0] tbl_q;
  logic       sel_tbl;
  logic       reg_we;
  logic       tbl_we;

  assign reg_we = we && (waddr < TABLE_LO);
  assign tbl_we = we && (waddr >= TABLE_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
      reg_q   <= '0;
      sel_tbl <= 1'b0;
    end else begin
      if (reg_we) begin
        if (waddr == LATCH_ADDR)
          regs[REG_AW'(waddr - SPACE_LO)] <= wdata & LATCH_KEEP;
        else
          regs[REG_AW'(waddr - SPACE_LO)] <= wdata;
      end
      reg_q   <= regs[REG_AW'(raddr - SPACE_LO)];
      sel_tbl <= (raddr >= TABLE_LO);
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) ram[TBL_AW'(waddr - TABLE_LO)] <= wdata;
    tbl_q <= ram[TBL_AW'(raddr - TABLE_LO)];
  end

  assign rdata    = sel_tbl ? tbl_q : reg_q;
  assign wr_latch = |(regs[LIDX] & LATCH_KEEP);

  // R3: nothing is ever stored outside the addressable space
  a_r3_write_range: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr >= SPACE_LO && waddr <= SPACE_HI));

  // R6: the latch register never holds anything but its latch bit
  a_r6_latch_bits: assert property (@(posedge clk) disable iff (rst)
    (regs[LIDX] & ~LATCH_KEEP) == 8'h00);
endmodule

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE   = 4'b1010,
  parameter logic [7:0] SPACE_LO   = 8'h80,
  parameter logic [7:0] SPACE_HI   = 8'hCF,
  parameter int         PAGE_BITS  = 4,
  parameter logic [7:0] SOLO_A     = 8'h80,
  parameter logic [7:0] SOLO_B     = 8'h85,
  parameter logic [7:0] LATCH_ADDR = 8'h86
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              busy,
  input  logic [2:0]        dev_pins,
  input  logic              wr_latch,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              sda_oe,
  output logic              we,
  output logic [BYTE_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              nv_start
);
  eng_state_t        state;
  rx_kind_t          kind;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txbyte;
  logic [BYTE_W-1:0] ptr;
  logic              ack_ok;
  logic              half;
  logic              locked;
  logic              rd_mode;
  logic              mack;
  logic              nv_pend;

  logic              dev_hit;
  logic              ptr_ok;
  logic              data_ok;
  logic              solo;
  logic [BYTE_W-1:0] page_next;
  logic [BYTE_W-1:0] seq_next;

  always_comb begin
    dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_pins);
    ptr_ok    = (shreg >= SPACE_LO) && (shreg <= SPACE_HI);
    data_ok   = !locked && (wr_latch || ptr == LATCH_ADDR);
    solo      = (ptr == SOLO_A) || (ptr == SOLO_B) || (ptr == LATCH_ADDR);
    page_next = {ptr[BYTE_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
    seq_next  = (ptr == SPACE_HI) ? SPACE_LO : ptr + 8'd1;
  end

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= RX_DEV;
      bitcnt   <= '0;
      shreg    <= '0;
      txbyte   <= '0;
      ptr      <= SPACE_LO;
      ack_ok   <= 1'b0;
      half     <= 1'b0;
      locked   <= 1'b0;
      rd_mode  <= 1'b0;
      mack     <= 1'b0;
      nv_pend  <= 1'b0;
      sda_oe   <= 1'b0;
      we       <= 1'b0;
      waddr    <= SPACE_LO;
      wdata    <= '0;
      nv_start <= 1'b0;
    end else begin
      we       <= 1'b0;
      nv_start <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        nv_start <= nv_pend;
        nv_pend  <= 1'b0;
      end else if (bus_start && !busy) begin
        state  <= ST_RX;
        kind   <= RX_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) state <= ST_DECIDE;
            end
          end
          ST_DECIDE: begin
            half  <= 1'b0;
            state <= ST_ACK;
            case (kind)
              RX_DEV: begin
                ack_ok  <= dev_hit;
                rd_mode <= shreg[0];
                kind    <= RX_PTR;
              end
              RX_PTR: begin
                ack_ok <= ptr_ok;
                if (ptr_ok) ptr <= shreg;
                locked <= 1'b0;
                kind   <= RX_DATA;
              end
              default: begin
                ack_ok <= data_ok;
                if (data_ok) begin
                  we     <= 1'b1;
                  waddr  <= ptr;
                  wdata  <= shreg;
                  ptr    <= page_next;
                  locked <= solo;
                  if (ptr != LATCH_ADDR) nv_pend <= 1'b1;
                end
              end
            endcase
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!half) begin
                sda_oe <= ack_ok;
                half   <= 1'b1;
              end else begin
                bitcnt <= '0;
                if (!ack_ok) begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end else if (rd_mode && kind == RX_PTR) begin
                  txbyte <= rd_data;
                  sda_oe <= ~rd_data[BYTE_W-1];
                  state  <= ST_TX;
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_RX;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                state <= ST_RACK;
                half  <= 1'b0;
                mack  <= 1'b0;
                ptr   <= seq_next;
              end
            end else if (scl_fall) begin
              txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txbyte[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise && half) mack <= ~sda_s;
            if (scl_fall) begin
              if (!half) begin
                sda_oe <= 1'b0;
                half   <= 1'b1;
              end else if (mack) begin
                txbyte <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the slave's SDA drive only moves while SCL is low
  a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R8: nothing is acknowledged or driven while the busy timer runs
  a_r8_quiet_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R6: a store to anything but the latch register needs the latch set
  a_r6_write_gate: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != LATCH_ADDR) |-> wr_latch);

  // R10: the line is only driven in the acknowledge and transmit states
  a_r10_drive_states: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ACK || state == ST_TX || state == ST_RACK));
endmodule

// File: rtl/tws_slave.sv
module tws_slave #(
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter logic [7:0] SPACE_LO    = 8'h80,
  parameter logic [7:0] SPACE_HI    = 8'hCF,
  parameter logic [7:0] TABLE_LO    = 8'h90,
  parameter int         PAGE_BITS   = 4,
  parameter logic [7:0] SOLO_A      = 8'h80,
  parameter logic [7:0] SOLO_B      = 8'h85,
  parameter logic [7:0] LATCH_ADDR  = 8'h86,
  parameter int         BUSY_CYCLES = 250000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] dev_pins,
  output logic       sda_pull,
  output logic       mem_we,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata
);
  logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic       busy, nv_start, wr_latch;
  logic [7:0] rd_addr, rd_data;

  tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tws_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .kick(nv_start), .busy(busy)
  );

  tws_store #(
    .SPACE_LO(SPACE_LO), .SPACE_HI(SPACE_HI), .TABLE_LO(TABLE_LO),
    .LATCH_ADDR(LATCH_ADDR), .LATCH_KEEP(8'h80)
  ) u_store (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data), .wr_latch(wr_latch)
  );

  tws_engine #(
    .DEV_TYPE(DEV_TYPE), .SPACE_LO(SPACE_LO), .SPACE_HI(SPACE_HI),
    .PAGE_BITS(PAGE_BITS), .SOLO_A(SOLO_A), .SOLO_B(SOLO_B),
    .LATCH_ADDR(LATCH_ADDR)
  ) u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .busy(busy),
    .dev_pins(dev_pins), .wr_latch(wr_latch), .rd_data(rd_data),
    .rd_addr(rd_addr), .sda_oe(sda_pull), .we(mem_we),
    .waddr(mem_addr), .wdata(mem_wdata), .nv_start(nv_start)
  );
endmodule

// File: tb/tws_slave_test.sv
module tws_slave_test;
  localparam int BUSY = 3000;
  localparam int Q    = 8;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull, mem_we;
  logic [7:0] mem_addr, mem_wdata;
  logic       sda_line;
  logic [2:0] pins = 3'b101;

  int checks = 0;
  int errors = 0;
  int r2_viol = 0;
  int log_n = 0;
  logic [7:0] log_a [64];
  logic [7:0] log_d [64];
  logic [7:0] rbuf  [32];
  logic [7:0] wbuf  [32];
  logic       prev_pull = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  tws_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .dev_pins(pins), .sda_pull(sda_pull), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (scl_m && (sda_pull != prev_pull)) r2_viol++;
      if (mem_we && log_n < 64) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
        log_n++;
      end
    end
    prev_pull = sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q / 2);
    ack = (sda_line == 1'b0);
    tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      b[i] = sda_line;
      tick(Q / 2);
      scl_m = 1'b0;
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // writes wbuf[0..n-1] from address a; returns how many data bytes got an ack
  task automatic write_seq(input logic [7:0] a, input int n, output logic hdr_ok, output int dacks);
    logic k1, k2, kd;
    dacks = 0;
    bus_start();
    send_byte(DEVW, k1);
    send_byte(a, k2);
    hdr_ok = k1 && k2;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], kd);
      if (kd) dacks++;
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [7:0] a, input int n, output logic ok);
    logic k1, k2, k3;
    bus_start();
    send_byte(DEVW, k1);
    send_byte(a, k2);
    bus_start();
    send_byte(DEVR, k3);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
    ok = k1 && k2 && k3;
  endtask

  task automatic t_reset();
    logic ok;
    check8("R12 sda released", {7'd0, sda_pull}, 8'h00);
    check8("R12 mem_we low", {7'd0, mem_we}, 8'h00);
    read_seq(8'h86, 1, ok);
    check8("R12 read acked (not busy)", {7'd0, ok}, 8'h01);
    check8("R12 latch clear", rbuf[0], 8'h00);
  endtask

  task automatic t_devaddr();
    logic k;
    bus_start();
    send_byte(8'hA0, k);
    check8("R1 pin mismatch nack", {7'd0, k}, 8'h00);
    send_byte(DEVW, k);
    check8("R1 ignored until start", {7'd0, k}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'hBA, k);
    check8("R1 wrong type nack", {7'd0, k}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(DEVW, k);
    check8("R1 match acked", {7'd0, k}, 8'h01);
    bus_stop();
  endtask

  task automatic t_latch_off();
    logic h; int d; int n0;
    n0 = log_n;
    wbuf[0] = 8'h33;
    write_seq(8'h90, 1, h, d);
    check8("R6 header acked", {7'd0, h}, 8'h01);
    check8("R6 data nack when latch clear", d[7:0], 8'h00);
    check8("R6 nothing stored", 8'(log_n - n0), 8'h00);
  endtask

  task automatic t_latch_on();
    logic h, ok; int d; int n0;
    n0 = log_n;
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    write_seq(8'h86, 2, h, d);
    check8("R7 only first byte after 86h acked", d[7:0], 8'h01);
    check8("R11 one pulse", 8'(log_n - n0), 8'h01);
    check8("R11 pulse address", log_a[n0], 8'h86);
    check8("R11 pulse data raw", log_d[n0], 8'hFF);
    read_seq(8'h86, 1, ok);
    check8("R8 no busy after 86h write", {7'd0, ok}, 8'h01);
    check8("R6 only bit 7 kept", rbuf[0], 8'h80);
  endtask

  task automatic t_solo();
    logic h; int d; int n0;
    n0 = log_n;
    wbuf[0] = 8'h5A; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    write_seq(8'h80, 3, h, d);
    check8("R7 single byte at 80h", d[7:0], 8'h01);
    check8("R7 one store", 8'(log_n - n0), 8'h01);
    tick(BUSY + 100);
  endtask

  task automatic t_page();
    logic h, k, ok; int d; int n0;
    n0 = log_n;
    for (int i = 0; i < 12; i++) wbuf[i] = 8'h10 + 8'(i);
    write_seq(8'h9B, 12, h, d);
    check8("R4 all twelve acked", d[7:0], 8'd12);
    check8("R11 twelve pulses", 8'(log_n - n0), 8'd12);
    check8("R4 fifth address 9Fh", log_a[n0 + 4], 8'h9F);
    check8("R4 wrap to 90h", log_a[n0 + 5], 8'h90);
    check8("R4 last address 96h", log_a[n0 + 11], 8'h96);
    bus_start();
    send_byte(DEVW, k);
    check8("R8 write probe ignored while busy", {7'd0, k}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(DEVR, k);
    check8("R8 read probe ignored while busy", {7'd0, k}, 8'h00);
    bus_stop();
    tick(BUSY + 100);
    read_seq(8'h90, 7, ok);
    check8("R8 acked after busy", {7'd0, ok}, 8'h01);
    for (int i = 0; i < 7; i++) check8("R4 wrapped bytes", rbuf[i], 8'h15 + 8'(i));
    read_seq(8'h9B, 5, ok);
    for (int i = 0; i < 5; i++) check8("R4 head bytes", rbuf[i], 8'h10 + 8'(i));
  endtask

  task automatic t_overrun();
    logic h, ok; int d;
    for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
    write_seq(8'hC0, 18, h, d);
    check8("R5 all eighteen acked", d[7:0], 8'd18);
    tick(BUSY + 100);
    read_seq(8'hC0, 17, ok);
    check8("R5 C0h overwritten", rbuf[0], 8'h50);
    check8("R5 C1h overwritten", rbuf[1], 8'h51);
    for (int i = 2; i < 16; i++) check8("R5 untouched tail", rbuf[i], 8'h40 + 8'(i));
    check8("R9 wrap CFh to 80h", rbuf[16], 8'h5A);
  endtask

  task automatic t_range();
    logic k;
    bus_start(); send_byte(DEVW, k); send_byte(8'hD0, k);
    check8("R3 D0h rejected", {7'd0, k}, 8'h00);
    bus_stop();
    bus_start(); send_byte(DEVW, k); send_byte(8'h7F, k);
    check8("R3 7Fh rejected", {7'd0, k}, 8'h00);
    bus_stop();
    bus_start(); send_byte(DEVW, k); send_byte(8'hCF, k);
    check8("R3 CFh accepted", {7'd0, k}, 8'h01);
    bus_stop();
  endtask

  task automatic t_master_nack();
    logic k; int pulled;
    pulled = 0;
    bus_start();
    send_byte(DEVW, k);
    send_byte(8'h80, k);
    bus_start();
    send_byte(DEVR, k);
    recv_byte(1'b0, rbuf[0]);
    check8("R9 single read of 80h", rbuf[0], 8'h5A);
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick(Q); if (sda_pull) pulled++;
      scl_m = 1'b1; tick(Q); if (sda_pull) pulled++;
      scl_m = 1'b0;
    end
    tick(Q);
    check8("R10 released after master nack", 8'(pulled), 8'h00);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_devaddr();
    t_latch_off();
    t_latch_on();
    t_solo();
    t_page();
    t_overrun();
    t_range();
    t_master_nack();
    check8("R2 drive changes only with SCL low", 8'(r2_viol), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule